// File: doc/BRIEF.md
# NAND Command Instruction Sequencer

This block runs a short program of 4-bit op-codes that issue command bytes to a NAND flash device. A start pulse copies an eight-slot instruction word into a shift register and freezes it. The slots then run one after another, beginning at the least significant nibble. Each command op-code selects one of four command bytes, applies it to the 8-bit data bus and pulses the command-latch and write strobes.

There are two kinds of command op-code. Immediate commands write at once. Wait commands first let a guard delay elapse. The length of that delay depends on a cycle-count setting and a relaxed-timing flag. After the guard, the block polls the ready/busy level and does not look for an edge. When ready is seen, the byte is written. If ready is never seen, the byte is still written once a programmable timeout expires, and a sticky timeout event flag is raised. The sequence ends at the first no-operation slot or after the eighth slot. The end is marked by a one-cycle done pulse.

The ready/busy input is assumed to be synchronous to `clk`.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, busy, done, cle and cmdTimeout are 0 and weN is 1.
- R2: Op-code encoding: 0x0 means no operation. 0x1 to 0x4 mean immediate command with entry 0 to 3. 0x5 and 0x6 mean wait command with entry 0 and entry 1. Every other value acts as no operation. Command entry n is cmdBytes[8n+7:8n].
- R3: A command write lasts two cycles with cle high in both. weN is low in the first cycle only. dataOut carries the selected byte and stays stable across both cycles.
- R4: Slot i is instrWord[4i+3:4i], and slots run in ascending order. After a start sampled at a clock edge, the first write begins one cycle later. Each immediate command starts three cycles after the previous write started.
- R5: The first no-operation or unknown slot ends the sequence and suppresses all later slots. If all eight slots hold commands, the sequence ends after the eighth write.
- R6: busy is high from the cycle after the start edge until the end of the done cycle. done is a single-cycle pulse. It comes one cycle after the ending slot is fetched, or two cycles after the eighth write starts.
- R7: A wait command writes nothing during a guard of 8*(2+cycleCount) cycles (relaxed = 0) or 16*(2+cycleCount) cycles (relaxed = 1). ready/busy is ignored during the guard, so a level already high at the end of the guard writes without any transition.
- R8: After the guard, ready/busy is sampled every cycle. The write begins in the cycle after the first sample that is high.
- R9: If ready/busy stays low for 2^(timeoutSel+8) sampled cycles after the guard, the write begins in the next cycle anyway and cmdTimeout goes high at that write's start.
- R10: cmdTimeout stays high until eventClr is asserted. Clearing takes effect at the next edge. A timeout in the same cycle takes priority over the clear.
- R11: A start while busy is ignored. The instruction word is captured only by an accepted start, so changing it during a sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| instrWord | input | 32 | Eight 4-bit op-code slots, slot 0 in the low nibble |
| cmdBytes | input | 32 | Four command bytes, entry n in bits 8n+7:8n |
| relaxed | input | 1 | Doubles the guard delay of wait commands |
| cycleCount | input | 4 | Cycle-count setting used for the guard delay |
| timeoutSel | input | 4 | Ready poll limit of 2^(timeoutSel+8) cycles |
| rdyBusy | input | 1 | Device ready (1) / busy (0) level |
| eventClr | input | 1 | Clears the timeout event flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cle | output | 1 | Command latch enable |
| weN | output | 1 | Active-low write enable |
| dataOut | output | 8 | Command byte on the data bus |
| cmdTimeout | output | 1 | Sticky wait-command timeout event |

## Verification
The hardest situations to reach are the ones that depend on where ready/busy changes relative to the guard window and the poll window.

The bench places ready/busy edges at chosen cycle offsets from the start edge:
- a level that goes high inside the guard and needs no transition afterwards;
- a level that goes high part way through polling after a relaxed, long guard;
- a level held low for the full 256-cycle limit.

For each case, the exact write cycle is predicted from the requirement formulas. A further case fires a second start with a different program in the middle of a running poll, to show that it is dropped.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_GUARD,
    S_POLL,
    S_WR1,
    S_WR2,
    S_FINISH
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInstr;
    logic advance;
    logic latchCmd;
    logic guardLoad;
    logic guardDec;
    logic toClear;
    logic toInc;
    logic setEvent;
  } seq_strobe_t;

endpackage

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int OP_W        = 4,
  parameter int BYTE_W      = 8,
  parameter int CMD_ENTRIES = 4,
  parameter int NUM_WAIT    = 2,
  parameter int SCY_W       = 4,
  parameter int TSEL_W      = 4,
  parameter int TO_BASE     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seq_strobe_t                   strobe,
  input  logic [NUM_SLOTS*OP_W-1:0]     instrWord,
  input  logic [CMD_ENTRIES*BYTE_W-1:0] cmdBytes,
  input  logic                          relaxed,
  input  logic [SCY_W-1:0]              cycleCount,
  input  logic [TSEL_W-1:0]             timeoutSel,
  input  logic                          eventClr,
  output logic                          opIsCmd,
  output logic                          opIsWait,
  output logic                          lastSlot,
  output logic                          guardDone,
  output logic                          toExpired,
  output logic [BYTE_W-1:0]             dataOut,
  output logic                          cmdTimeout
);

  localparam int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int IDX_W   = (CMD_ENTRIES > 1) ? $clog2(CMD_ENTRIES) : 1;
  localparam int GUARD_W = SCY_W + 6;
  localparam int TO_W    = TO_BASE + (1 << TSEL_W);
  localparam int SH_W    = $clog2(TO_W) + 1;
  localparam logic [OP_W-1:0] CM_FIRST = OP_W'(1);
  localparam logic [OP_W-1:0] CM_LAST  = OP_W'(CMD_ENTRIES);
  localparam logic [OP_W-1:0] CW_FIRST = OP_W'(CMD_ENTRIES + 1);
  localparam logic [OP_W-1:0] CW_LAST  = OP_W'(CMD_ENTRIES + NUM_WAIT);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [NUM_SLOTS*OP_W-1:0] instrSr;
  logic [SLOT_W-1:0]         slotCnt;
  logic [OP_W-1:0]           curOp;
  logic [IDX_W-1:0]          cmdIdx;
  logic [BYTE_W-1:0]         cmdTable [CMD_ENTRIES];
  logic [GUARD_W-1:0]        guardCnt;
  logic [GUARD_W-1:0]        guardSpan;
  logic [GUARD_W-1:0]        guardInit;
  logic [TO_W-1:0]           toCnt;
  logic [TO_W-1:0]           toLimit;
  logic [SH_W-1:0]           toShift;

  // instruction shift register and slot counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrSr <= '0;
      slotCnt <= '0;
    end else if (strobe.loadInstr) begin
      instrSr <= instrWord;
      slotCnt <= '0;
    end else if (strobe.advance) begin
      instrSr <= instrSr >> OP_W;
      slotCnt <= slotCnt + SLOT_W'(1);
    end
  end

  assign curOp    = instrSr[OP_W-1:0];
  assign lastSlot = (slotCnt == SLOT_LAST);

  // op-code decode
  always_comb begin
    opIsCmd  = (curOp >= CM_FIRST) && (curOp <= CM_LAST);
    opIsWait = (curOp >= CW_FIRST) && (curOp <= CW_LAST);
    cmdIdx   = opIsCmd ? IDX_W'(curOp - CM_FIRST) : IDX_W'(curOp - CW_FIRST);
  end

  // command byte table
  for (genvar g = 0; g < CMD_ENTRIES; g++) begin : g_cmdTable
    assign cmdTable[g] = cmdBytes[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobe.latchCmd) begin
      dataOut <= cmdTable[cmdIdx];
    end
  end

  // guard delay: (2+scy) * 8 or * 16
  always_comb begin
    guardSpan = GUARD_W'(2) + GUARD_W'(cycleCount);
    guardInit = relaxed ? (guardSpan << 4) : (guardSpan << 3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (strobe.guardLoad) begin
      guardCnt <= guardInit;
    end else if (strobe.guardDec) begin
      guardCnt <= guardCnt - GUARD_W'(1);
    end
  end

  assign guardDone = (guardCnt == GUARD_W'(1));

  // poll timeout: 2^(sel+base) cycles
  always_comb begin
    toShift = SH_W'(timeoutSel) + SH_W'(TO_BASE);
    toLimit = (TO_W'(1) << toShift) - TO_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (strobe.toClear) begin
      toCnt <= '0;
    end else if (strobe.toInc) begin
      toCnt <= toCnt + TO_W'(1);
    end
  end

  assign toExpired = (toCnt == toLimit);

  // sticky timeout event, set has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdTimeout <= 1'b0;
    end else if (strobe.setEvent) begin
      cmdTimeout <= 1'b1;
    end else if (eventClr) begin
      cmdTimeout <= 1'b0;
    end
  end

endmodule

// File: rtl/nand_seq_control.sv
module nand_seq_control
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        opIsCmd,
  input  logic        opIsWait,
  input  logic        lastSlot,
  input  logic        guardDone,
  input  logic        toExpired,
  input  logic        rdyBusy,
  output seq_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        cle,
  output logic        weN
);

  seq_state_e state;
  seq_state_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.loadInstr = 1'b1;
          stateNext        = S_FETCH;
        end
      end
      S_FETCH: begin
        if (opIsCmd) begin
          strobe.latchCmd = 1'b1;
          stateNext       = S_WR1;
        end else if (opIsWait) begin
          strobe.guardLoad = 1'b1;
          stateNext        = S_GUARD;
        end else begin
          stateNext = S_FINISH;
        end
      end
      S_GUARD: begin
        if (guardDone) begin
          strobe.toClear = 1'b1;
          stateNext      = S_POLL;
        end else begin
          strobe.guardDec = 1'b1;
        end
      end
      S_POLL: begin
        if (rdyBusy) begin
          strobe.latchCmd = 1'b1;
          stateNext       = S_WR1;
        end else if (toExpired) begin
          strobe.latchCmd = 1'b1;
          strobe.setEvent = 1'b1;
          stateNext       = S_WR1;
        end else begin
          strobe.toInc = 1'b1;
        end
      end
      S_WR1: begin
        stateNext = S_WR2;
      end
      S_WR2: begin
        strobe.advance = 1'b1;
        stateNext      = lastSlot ? S_FINISH : S_FETCH;
      end
      S_FINISH: begin
        stateNext = S_IDLE;
      end
      default: begin
        stateNext = S_IDLE;
      end
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);
  assign cle  = (state == S_WR1) || (state == S_WR2);
  assign weN  = (state != S_WR1);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int OP_W        = 4,
  parameter int BYTE_W      = 8,
  parameter int CMD_ENTRIES = 4,
  parameter int NUM_WAIT    = 2,
  parameter int SCY_W       = 4,
  parameter int TSEL_W      = 4,
  parameter int TO_BASE     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_SLOTS*OP_W-1:0]     instrWord,
  input  logic [CMD_ENTRIES*BYTE_W-1:0] cmdBytes,
  input  logic                          relaxed,
  input  logic [SCY_W-1:0]              cycleCount,
  input  logic [TSEL_W-1:0]             timeoutSel,
  input  logic                          rdyBusy,
  input  logic                          eventClr,
  output logic                          busy,
  output logic                          done,
  output logic                          cle,
  output logic                          weN,
  output logic [BYTE_W-1:0]             dataOut,
  output logic                          cmdTimeout
);

  seq_strobe_t strobe;
  logic opIsCmd;
  logic opIsWait;
  logic lastSlot;
  logic guardDone;
  logic toExpired;

  nand_seq_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opIsCmd   (opIsCmd),
    .opIsWait  (opIsWait),
    .lastSlot  (lastSlot),
    .guardDone (guardDone),
    .toExpired (toExpired),
    .rdyBusy   (rdyBusy),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .cle       (cle),
    .weN       (weN)
  );

  nand_seq_datapath #(
    .NUM_SLOTS   (NUM_SLOTS),
    .OP_W        (OP_W),
    .BYTE_W      (BYTE_W),
    .CMD_ENTRIES (CMD_ENTRIES),
    .NUM_WAIT    (NUM_WAIT),
    .SCY_W       (SCY_W),
    .TSEL_W      (TSEL_W),
    .TO_BASE     (TO_BASE)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instrWord  (instrWord),
    .cmdBytes   (cmdBytes),
    .relaxed    (relaxed),
    .cycleCount (cycleCount),
    .timeoutSel (timeoutSel),
    .eventClr   (eventClr),
    .opIsCmd    (opIsCmd),
    .opIsWait   (opIsWait),
    .lastSlot   (lastSlot),
    .guardDone  (guardDone),
    .toExpired  (toExpired),
    .dataOut    (dataOut),
    .cmdTimeout (cmdTimeout)
  );

endmodule

// File: rtl/nand_cmd_seq_checker.sv
module nand_cmd_seq_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              eventClr,
  input logic              busy,
  input logic              done,
  input logic              cle,
  input logic              weN,
  input logic [BYTE_W-1:0] dataOut,
  input logic              cmdTimeout
);

  // R3: write strobe only inside a command latch window
  a_r3_we_inside_cle: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> cle);

  // R3: second cycle keeps cle, releases we, data stable
  a_r3_pulse_shape: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> (cle && weN && $stable(dataOut)));

  // R3: the second pulse cycle is never followed by another low write strobe
  a_r3_single_we: assert property (@(posedge clk) disable iff (!rstN)
    (cle && weN) |=> weN);

  // R6: done lasts one cycle and busy drops after it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R6: done and strobes only while busy
  a_r6_strobes_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (done || cle) |-> busy);

  // R9: the event flag rises together with the start of a write
  a_r9_event_with_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdTimeout) |-> (cle && !weN));

  // R10: the flag is sticky without a clear
  a_r10_event_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cmdTimeout && !eventClr) |=> cmdTimeout);

endmodule

bind nand_cmd_seq nand_cmd_seq_checker #(.BYTE_W(BYTE_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .eventClr   (eventClr),
  .busy       (busy),
  .done       (done),
  .cle        (cle),
  .weN        (weN),
  .dataOut    (dataOut),
  .cmdTimeout (cmdTimeout)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] cmdBytes = '0;
  logic        relaxed = 1'b0;
  logic [3:0]  cycleCount = '0;
  logic [3:0]  timeoutSel = '0;
  logic        rdyBusy = 1'b1;
  logic        eventClr = 1'b0;
  logic        busy, done, cle, weN, cmdTimeout;
  logic [7:0]  dataOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdyMode = 0;   // 0 high, 1 low, 2 high from rdyAt on
  int rdyAt = 0;
  bit expFlag = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] data;
    int         at;
    bit         flag;
    string      req;
  } wr_item_t;

  wr_item_t expQ[$];
  int       doneQ[$];

  always #2.5 clk = ~clk;   // 200 MHz

  nand_cmd_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .cmdBytes(cmdBytes), .relaxed(relaxed), .cycleCount(cycleCount),
    .timeoutSel(timeoutSel), .rdyBusy(rdyBusy), .eventClr(eventClr),
    .busy(busy), .done(done), .cle(cle), .weN(weN), .dataOut(dataOut),
    .cmdTimeout(cmdTimeout)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit rdyModel(input int p);
    if (rdyMode == 0) return 1'b1;
    if (rdyMode == 1) return 1'b0;
    return p >= rdyAt;
  endfunction

  // ready/busy driver, updated away from the clock edge
  always @(negedge clk) rdyBusy = rdyModel(cyc);

  // monitor: pops expected writes and done pulses
  bit         holdPending = 1'b0;
  logic [7:0] holdData;
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPending) begin
        check(cle && weN && dataOut == holdData, "R3", "second pulse cycle",
              {cle, weN, dataOut}, {2'b11, holdData});
        holdPending = 1'b0;
      end
      if (cle && !weN) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11", "unexpected write", dataOut, 0);
        end else begin
          wr_item_t it;
          it = expQ.pop_front();
          check(dataOut == it.data, "R2/R3", "command byte", dataOut, it.data);
          check(cyc == it.at, it.req, "write start cycle", cyc, it.at);
          check(cmdTimeout == it.flag, "R9", "event flag at write", cmdTimeout, it.flag);
          holdPending = 1'b1;
          holdData = dataOut;
        end
      end
      if (done) begin
        if (doneQ.size() == 0) begin
          check(1'b0, "R6", "unexpected done", cyc, 0);
        end else begin
          int d;
          d = doneQ.pop_front();
          check(cyc == d, "R5/R6", "done cycle", cyc, d);
          check(busy == 1'b1, "R6", "busy during done", busy, 1);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver: computes expectations from the requirements and starts a sequence
  task automatic runSeq(input logic [31:0] instr, input logic [31:0] cmds,
                        input logic rlx, input logic [3:0] scy, input logic [3:0] tsel,
                        input int mode, input int rdyRel);
    int t, k, g, lim, w, p0, op, doneAt;
    bit to, ended;
    @(negedge clk);
    instrWord = instr; cmdBytes = cmds; relaxed = rlx;
    cycleCount = scy; timeoutSel = tsel;
    k = cyc + 1;
    rdyMode = mode;
    rdyAt = k + rdyRel;
    t = k;
    ended = 1'b0;
    doneAt = 0;
    for (int i = 0; i < 8 && !ended; i++) begin
      op = int'(instr[4*i +: 4]);
      if (op >= 1 && op <= 4) begin
        w = t + 1;
        expQ.push_back('{cmds[(op-1)*8 +: 8], w, expFlag, "R4"});
        t = w + 2;
      end else if (op == 5 || op == 6) begin
        g = (rlx ? 16 : 8) * (2 + int'(scy));
        lim = 1 << (int'(tsel) + 8);
        p0 = t + g + 1;
        w = -1;
        to = 1'b0;
        for (int p = p0; p < p0 + lim; p++) begin
          if (rdyModel(p)) begin w = p + 1; break; end
        end
        if (w < 0) begin w = p0 + lim; to = 1'b1; end
        expFlag = expFlag | to;
        expQ.push_back('{cmds[(op-5)*8 +: 8], w, expFlag,
                         to ? "R9" : ((w == p0 + 1) ? "R7" : "R8")});
        t = w + 2;
      end else begin
        doneAt = t + 1;
        ended = 1'b1;
      end
    end
    if (!ended) doneAt = t;
    doneQ.push_back(doneAt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", busy, 1);
    while (doneQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && expQ.size() == 0, "R6", "idle after done",
          {busy, 8'(expQ.size())}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cle == 0 && weN == 1 && cmdTimeout == 0,
          "R1", "reset outputs", {busy, done, cle, weN, cmdTimeout}, 5'b00010);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cle == 0 && weN == 1 && cmdTimeout == 0,
          "R1", "idle outputs", {busy, done, cle, weN, cmdTimeout}, 5'b00010);

    // R2 R3 R4: all four immediate commands, shuffled order, then NOP
    runSeq(32'h0001_3241, 32'hD4_C3_B2_A1, 1'b0, 4'd0, 4'd0, 0, 0);
    // R5: eight commands, no NOP slot
    runSeq(32'h4321_1234, 32'h70_60_50_40, 1'b0, 4'd0, 4'd0, 0, 0);
    // R2 R5: unknown code 0x9 stops the sequence; later slots are dropped
    runSeq(32'h0003_4921, 32'h11_22_33_44, 1'b0, 4'd0, 4'd0, 0, 0);
    // R2 R5: code 0xF as first slot gives an empty sequence
    runSeq(32'h0000_001F, 32'h11_22_33_44, 1'b0, 4'd0, 4'd0, 0, 0);
    // R7: wait command with ready high, strict timing
    runSeq(32'h0000_0151, 32'h00_00_5A_E1, 1'b0, 4'd0, 4'd0, 0, 0);
    // R7: ready rises inside the guard, no transition seen after it
    runSeq(32'h0000_0005, 32'h00_00_00_3C, 1'b0, 4'd2, 4'd0, 2, 5);
    // R8: relaxed, long guard, ready rises part way through polling
    runSeq(32'h0000_0362, 32'h00_9F_70_88, 1'b1, 4'd3, 4'd0, 2, 120);
    check(cmdTimeout == 1'b0, "R8", "no event when ready", cmdTimeout, 0);
    // R9: ready held low past the timeout
    runSeq(32'h0000_0016, 32'h00_00_FF_31, 1'b0, 4'd0, 4'd0, 1, 0);
    // R10: flag holds across idle cycles and a further sequence
    repeat (10) @(negedge clk);
    check(cmdTimeout == 1'b1, "R10", "flag sticky", cmdTimeout, 1);
    runSeq(32'h0000_0002, 32'h00_00_66_00, 1'b0, 4'd0, 4'd0, 0, 0);
    eventClr = 1'b1;
    @(negedge clk);
    eventClr = 1'b0;
    expFlag = 1'b0;
    check(cmdTimeout == 1'b0, "R10", "flag cleared", cmdTimeout, 0);

    // R11: second start with another program while a poll is running
    fork
      runSeq(32'h0000_0015, 32'h00_00_2B_1A, 1'b0, 4'd0, 4'd1, 2, 150);
      begin
        repeat (40) @(negedge clk);
        instrWord = 32'h4444_4444;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && expQ.size() == 0, "R11", "no extra activity",
          busy, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule